// File: doc/BRIEF.md
# Frequency-Locked Speed Discriminator

This block sits in a motor speed loop and judges the spacing of feedback pulses from a frequency generator attached to the motor. A fast counting clock drives every register. The block measures each feedback period as a number of counting-clock cycles and compares it with a nominal count chosen by a two-bit select input. The loop regulates the motor so that the feedback pulse rate matches the reference pulse rate, so the counting clock is expected to run at a nominal-count multiple of the reference. A period shorter than the nominal count means the motor is running too fast.

From each measurement the block produces two flags. An active-low overspeed flag marks a period that is too short. An active-low lock flag marks a period that lies within one sixteenth (6.25 %) of the nominal count. Both flags are registered and change only when a measurement completes. A separate half-rate phase comparator divides the reference and feedback pulse trains by two. Its output is a pulse whose width encodes how far the divided reference runs ahead of the divided feedback. Both pulse inputs must already be synchronized to the counting clock, with each pulse lasting one cycle.

Top module: `spdisc_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, fast_n is 1, lock_n is 1 and phase_out is 0.
- R2: count_sel picks the nominal count N = 2^(BASE_SHIFT+count_sel). With the defaults, the codes 0, 1, 2 and 3 give 256, 512, 1024 and 2048.
- R3: A period is the number of counting-clock cycles between two consecutive feedback pulses. The first feedback pulse after reset only starts a measurement and leaves both flags unchanged.
- R4: On the clock edge that samples a feedback pulse ending a period, fast_n becomes 0 if the period is less than N and 1 otherwise.
- R5: On the same edge, lock_n becomes 0 if N - N/16 <= period <= N + N/16, with both bounds included, and 1 otherwise.
- R6: fast_n and lock_n hold their values on every cycle without a feedback pulse.
- R7: The period counter saturates at 2^CW - 1. An overlong gap is therefore judged slow and unlocked.
- R8: Each reference pulse toggles a divide-by-two reference state. Each feedback pulse toggles a divide-by-two feedback state.
- R9: phase_out goes to 1 on the edge where the divided reference rises. It goes to 0 on the edge where the divided feedback rises, and this takes precedence when both rise on the same edge. Otherwise phase_out holds.
- R10: count_sel is read at the edge that ends a period, so a new selection applies to the period that ends next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | Synchronized one-cycle reference pulse |
| fb_pulse | input | 1 | Synchronized one-cycle feedback (FG) pulse |
| count_sel | input | 2 | Nominal count select |
| fast_n | output | 1 | Low after a period shorter than nominal |
| phase_out | output | 1 | Half-rate phase comparison output |
| lock_n | output | 1 | Low while the last period is within ±1/16 of nominal |

## Verification
The bench builds the block with BASE_SHIFT = 5 and CW = 10. This gives nominal counts of 32 to 256 and windows of ±2 to ±16 cycles. At these sizes each exact window edge (N-N/16-1, N-N/16, N-1, N, N+N/16, N+N/16+1) costs only a few hundred cycles to test, and a gap of about a thousand cycles reaches counter saturation. Many random periods around every select code then fit in a short run. A separate random pulse phase drives both inputs and checks the divided states and the phase output cycle by cycle.

// File: rtl/spdisc_pkg.sv
package spdisc_pkg;

    typedef enum logic [1:0] {
        SPAN_X1 = 2'd0,
        SPAN_X2 = 2'd1,
        SPAN_X4 = 2'd2,
        SPAN_X8 = 2'd3
    } span_e;

    typedef struct packed {
        logic fast_n;
        logic lock_n;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{fast_n: 1'b1, lock_n: 1'b1};

    localparam int unsigned SPAN_COUNT = 4;
    localparam int unsigned WIN_SHIFT  = 4;

    function automatic int unsigned nominal_of(input int unsigned base_shift,
                                               input int unsigned span);
        return 32'd1 << (base_shift + span);
    endfunction

    function automatic int unsigned window_lo(input int unsigned nom);
        return nom - (nom >> WIN_SHIFT);
    endfunction

    function automatic int unsigned window_hi(input int unsigned nom);
        return nom + (nom >> WIN_SHIFT);
    endfunction

endpackage

// File: rtl/spdisc_period_meter.sv
module spdisc_period_meter #(
    parameter int unsigned CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fb_pulse,
    output logic [CW-1:0] period,
    output logic          period_valid
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_next;
    logic          primed;

    // Saturating increment; the value captured on a pulse includes the pulse cycle.
    always_comb begin
        if (cnt == CNT_MAX) begin
            cnt_next = CNT_MAX;
        end else begin
            cnt_next = cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            primed <= 1'b0;
        end else if (fb_pulse) begin
            cnt    <= '0;
            primed <= 1'b1;
        end else begin
            cnt    <= cnt_next;
        end
    end

    assign period       = cnt_next;
    assign period_valid = fb_pulse & primed;

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !fb_pulse) |=> (cnt == CNT_MAX)); // R7

    AST_ARMED_STAYS: assert property (@(posedge clk) disable iff (rst)
        primed |=> primed); // R3

endmodule

// File: rtl/spdisc_judge.sv
module spdisc_judge
    import spdisc_pkg::*;
#(
    parameter int unsigned CW         = 13,
    parameter int unsigned BASE_SHIFT = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    sel,
    input  logic [CW-1:0] period,
    input  logic          period_valid,
    output verdict_t      verdict
);

    logic [CW-1:0] nom_t [SPAN_COUNT];
    logic [CW-1:0] lo_t  [SPAN_COUNT];
    logic [CW-1:0] hi_t  [SPAN_COUNT];

    generate
        for (genvar g = 0; g < SPAN_COUNT; g++) begin : g_span
            localparam int unsigned NOM = nominal_of(BASE_SHIFT, g);
            assign nom_t[g] = CW'(NOM);
            assign lo_t[g]  = CW'(window_lo(NOM));
            assign hi_t[g]  = CW'(window_hi(NOM));
        end
    endgenerate

    span_e    span;
    logic     is_fast;
    logic     in_window;
    verdict_t verdict_d;

    always_comb begin
        span             = span_e'(sel);
        is_fast          = period < nom_t[span];
        in_window        = (period >= lo_t[span]) && (period <= hi_t[span]);
        verdict_d.fast_n = ~is_fast;
        verdict_d.lock_n = ~in_window;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= VERDICT_IDLE;
        end else if (period_valid) begin
            verdict <= verdict_d;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !period_valid |=> $stable(verdict)); // R6

    AST_FAR_SLOW: assert property (@(posedge clk) disable iff (rst)
        (period_valid && period > hi_t[span]) |=> (verdict.fast_n && verdict.lock_n)); // R5

    AST_FAR_FAST: assert property (@(posedge clk) disable iff (rst)
        (period_valid && period < lo_t[span]) |=> (!verdict.fast_n && verdict.lock_n)); // R4

endmodule

// File: rtl/spdisc_phase.sv
module spdisc_phase (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic fb_pulse,
    output logic phase_out
);

    logic ref_div;
    logic fb_div;
    logic ref_rise;
    logic fb_rise;

    always_comb begin
        ref_rise = ref_pulse & ~ref_div;
        fb_rise  = fb_pulse  & ~fb_div;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_div   <= 1'b0;
            fb_div    <= 1'b0;
            phase_out <= 1'b0;
        end else begin
            if (ref_pulse) ref_div <= ~ref_div;
            if (fb_pulse)  fb_div  <= ~fb_div;
            if (fb_rise) begin
                phase_out <= 1'b0;
            end else if (ref_rise) begin
                phase_out <= 1'b1;
            end
        end
    end

    AST_REF_HALVES: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> (ref_div != $past(ref_div))); // R8

    AST_FB_WINS: assert property (@(posedge clk) disable iff (rst)
        fb_rise |=> !phase_out); // R9

    AST_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ref_pulse && !fb_pulse) |=> $stable(phase_out)); // R9

endmodule

// File: rtl/spdisc_top.sv
module spdisc_top
    import spdisc_pkg::*;
#(
    parameter int unsigned CW         = 13,
    parameter int unsigned BASE_SHIFT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_pulse,
    input  logic       fb_pulse,
    input  logic [1:0] count_sel,
    output logic       fast_n,
    output logic       phase_out,
    output logic       lock_n
);

    logic [CW-1:0] period;
    logic          period_valid;
    verdict_t      verdict;

    spdisc_period_meter #(.CW(CW)) u_meter (
        .clk          (clk),
        .rst          (rst),
        .fb_pulse     (fb_pulse),
        .period       (period),
        .period_valid (period_valid)
    );

    spdisc_judge #(.CW(CW), .BASE_SHIFT(BASE_SHIFT)) u_judge (
        .clk          (clk),
        .rst          (rst),
        .sel          (count_sel),
        .period       (period),
        .period_valid (period_valid),
        .verdict      (verdict)
    );

    spdisc_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .phase_out (phase_out)
    );

    assign fast_n = verdict.fast_n;
    assign lock_n = verdict.lock_n;

    AST_FLAGS_MOVE_ON_FB: assert property (@(posedge clk) disable iff (rst)
        !fb_pulse |=> ($stable(fast_n) && $stable(lock_n))); // R6

endmodule

// File: tb/spdisc_top_bench.sv
module spdisc_top_bench;

    localparam int CW   = 10;
    localparam int BS   = 5;
    localparam int CMAX = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pulse = 1'b0;
    logic       fb_pulse = 1'b0;
    logic [1:0] count_sel = 2'd0;
    logic       fast_n;
    logic       phase_out;
    logic       lock_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    logic exp_fast_n, exp_lock_n, primed;
    logic m_ref_div, m_fb_div, m_phase;

    always #10 clk = ~clk;

    spdisc_top #(.CW(CW), .BASE_SHIFT(BS)) u_spdisc_top (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .count_sel (count_sel),
        .fast_n    (fast_n),
        .phase_out (phase_out),
        .lock_n    (lock_n)
    );

    function automatic int nom_of(input int sel);
        return 1 << (BS + sel);
    endfunction

    function automatic int lo_of(input int sel);
        return nom_of(sel) - nom_of(sel) / 16;
    endfunction

    function automatic int hi_of(input int sel);
        return nom_of(sel) + nom_of(sel) / 16;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_pulse = 1'b0;
        fb_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_fast_n = 1'b1;
        exp_lock_n = 1'b1;
        primed = 1'b0;
        m_ref_div = 1'b0;
        m_fb_div = 1'b0;
        m_phase = 1'b0;
    endtask

    // Feedback pulse 'gap' cycles after the previous one, then check flags.
    task automatic fb_after(input int gap, input int sel, input string req);
        int meas;
        count_sel = 2'(sel);
        for (int i = 1; i < gap; i++) begin
            @(negedge clk);
            if (i == gap / 2) begin
                check("R6 hold fast_n", int'(fast_n), int'(exp_fast_n));
                check("R6 hold lock_n", int'(lock_n), int'(exp_lock_n));
            end
        end
        fb_pulse = 1'b1;
        @(negedge clk);
        fb_pulse = 1'b0;
        meas = (gap > CMAX) ? CMAX : gap;
        if (primed) begin
            exp_fast_n = !(meas < nom_of(sel));
            exp_lock_n = !(meas >= lo_of(sel) && meas <= hi_of(sel));
        end
        primed = 1'b1;
        check({req, " fast_n"}, int'(fast_n), int'(exp_fast_n));
        check({req, " lock_n"}, int'(lock_n), int'(exp_lock_n));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);

        // R1: reset state
        do_reset();
        check("R1 fast_n", int'(fast_n), 1);
        check("R1 lock_n", int'(lock_n), 1);
        check("R1 phase_out", int'(phase_out), 0);

        // R8, R9: random pulse traces against the divide-by-two model
        for (int c = 0; c < 600; c++) begin
            logic r, f, rr, fr;
            r = ($urandom % 4) == 0;
            f = ($urandom % 4) == 0;
            if (c == 10) begin r = 1'b1; f = 1'b1; end
            ref_pulse = r;
            fb_pulse = f;
            @(negedge clk);
            rr = r & ~m_ref_div;
            fr = f & ~m_fb_div;
            if (fr) m_phase = 1'b0;
            else if (rr) m_phase = 1'b1;
            if (r) m_ref_div = ~m_ref_div;
            if (f) m_fb_div = ~m_fb_div;
            check("R8/R9 phase_out", int'(phase_out), int'(m_phase));
        end
        ref_pulse = 1'b0;
        fb_pulse = 1'b0;

        // R3: first pulse after reset only arms (period would lie in window)
        do_reset();
        fb_after(nom_of(2), 2, "R3 first pulse");
        check("R3 lock_n stays high", int'(lock_n), 1);

        // R4, R5, R2: exact window edges at sel=2 (N=128, window 120..136)
        fb_after(119, 2, "R5 below window");
        fb_after(120, 2, "R5 low edge");
        fb_after(127, 2, "R4 just fast");
        fb_after(128, 2, "R4 nominal");
        fb_after(136, 2, "R5 high edge");
        fb_after(137, 2, "R5 above window");

        // R2: every select code at its nominal count and below the window
        for (int s = 0; s < 4; s++) begin
            fb_after(nom_of(s), s, "R2 nominal");
            fb_after(lo_of(s) - 1, s, "R2 fast");
        end

        // R7: saturation on an overlong gap
        fb_after(1100, 0, "R7 saturated");
        fb_after(1, 0, "R4 single-cycle period");

        // R10: a select change applies to the period ending next
        fb_after(128, 0, "R10 slow at sel0");
        fb_after(128, 2, "R10 locked at sel2");
        check("R10 lock_n", int'(lock_n), 0);

        // Random periods around each nominal count
        for (int k = 0; k < 80; k++) begin
            int s, n, g;
            s = int'($urandom % 4);
            n = nom_of(s);
            g = n - n / 8 + int'($urandom % (n / 4 + 1));
            if (g < 1) g = 1;
            fb_after(g, s, "R4/R5 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule